// File: doc/BRIEF.md
# Counter Control and Read Register Frames

This block is the memory-mapped register front end of a free-running system counter. A simple bus reaches it through two register frames. Every request carries a security attribute, and every request is accepted in the cycle it is presented. The control frame holds the counter's configuration and identification words, and only secure requests may use it. The read frame exposes only the 64-bit current count, and it serves both secure and non-secure reads. The counter datapath sits outside this block. It receives the configuration through output ports and returns its count and running state through input ports.

Two rules govern configuration writes:

- The counter can be enabled only when the chosen update-frequency index points at a live entry of the frequency table.
- The scale increment and the scale-enable bit are frozen while the counter is enabled.

A halt-on-debug control combines with an external debug request to stop the counter.

Top module: `cnt_frames`

## Requirements
- R1: Every request is accepted in the cycle it is presented (`req_ready` high). `rsp_valid` is high exactly in the following cycle, together with `rsp_err` and `rsp_rdata`.
- R2: A non-secure request (`req_nsec`=1) to the control frame (`req_frame`=0) has these effects:
  - It returns read data 0 and `rsp_err`=1.
  - If it is a write, it changes no register.
- R3: Reads of the read frame (`req_frame`=1) return the count and `rsp_err`=0, whether secure or non-secure:
  - Offset 0x08 returns `cnt_value[31:0]`.
  - Offset 0x0C returns `cnt_value[63:32]`.
  - Every other offset reads 0.
- R4: A write to the read frame changes no register and returns `rsp_err`=1.
- R5: The control word at offset 0x00 of the control frame reads back and drives the output ports. Its fields are:
  - bit 0: counter enable
  - bit 1: halt-on-debug
  - bit 2: scale enable
  - bits [8 +: FSEL_W]: update-frequency select
  - all other bits: zero
- R6: A control write sets enable only if the written enable bit is 1 and the written select index names a valid table entry. Valid means the index is inside the table and that entry and every entry before it are nonzero. Any other control write leaves enable at 0.
- R7: While enable is 1, writes to the scale increment (offset 0x10) and to the scale-enable bit are ignored.
- R8: The status word at offset 0x04 carries two bits:
  - bit 0: the `cnt_running` input
  - bit 1: the `ctl_halt` output
- R9: The identification word at offset 0x1C has bit 0 set when scaling is implemented. All its other bits are 0.
- R10: The frequency table is read at offsets 0x20 + 4·n, one 32-bit entry per index n. Offsets past the last entry read 0. The default table is 100000000, 50000000, 0, 12000000.
- R11: `ctl_halt` is high exactly when the halt-on-debug bit and `dbg_req` are both high.
- R12: After reset the control word and scale increment are 0, and all control outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_nsec | input | 1 | 1 = non-secure request |
| req_frame | input | 1 | 0 = control frame, 1 = read frame |
| req_addr | input | 8 | Byte offset inside the frame |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Access refused |
| rsp_rdata | output | 32 | Read data |
| cnt_value | input | 64 | Integer count from the datapath |
| cnt_running | input | 1 | Datapath reports it is counting |
| dbg_req | input | 1 | Debug halt request |
| ctl_enable | output | 1 | Counter enable |
| ctl_scale_en | output | 1 | Scaling enable |
| ctl_freq_sel | output | FSEL_W | Selected frequency-table index |
| ctl_scale_inc | output | 32 | Scale increment, 8.24 fixed point |
| ctl_halt | output | 1 | Halt request to the datapath |

## Verification
The bench tries to enable the counter with select indices that must be refused. One index points at the zero terminator and one points at a nonzero entry that lies beyond the terminator. A design that checks only the addressed entry, or that latches enable regardless, would start counting. Once the counter runs, the bench rewrites the scale increment and clears scale enable; a missing freeze shows up as a changed readback or output. Non-secure control-frame accesses and read-frame writes are checked for both the error flag and an unchanged control state. This catches designs that flag the error but still commit the write, or that leak data on a refused read.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  localparam int CFR_AW = 8;
  localparam int CFR_DW = 32;

  localparam logic [CFR_AW-1:0] OFS_CTRL   = 8'h00;
  localparam logic [CFR_AW-1:0] OFS_STAT   = 8'h04;
  localparam logic [CFR_AW-1:0] OFS_CNT_LO = 8'h08;
  localparam logic [CFR_AW-1:0] OFS_CNT_HI = 8'h0C;
  localparam logic [CFR_AW-1:0] OFS_SCALE  = 8'h10;
  localparam logic [CFR_AW-1:0] OFS_IDENT  = 8'h1C;
  localparam logic [CFR_AW-1:0] OFS_FTAB   = 8'h20;

  localparam int BIT_EN    = 0;
  localparam int BIT_HALT  = 1;
  localparam int BIT_SCALE = 2;
  localparam int FSEL_LSB  = 8;

  typedef enum logic {FRAME_CTRL = 1'b0, FRAME_READ = 1'b1} frame_e;

  // table entry n lives at OFS_FTAB + 4n
  function automatic logic [CFR_AW-1:0] ftab_ofs(input int n);
    return OFS_FTAB + CFR_AW'(4 * n);
  endfunction
endpackage

// File: rtl/cfr_decode.sv
module cfr_decode
  import cfr_pkg::*;
(
  input  logic              acc,
  input  logic              req_write,
  input  logic              req_nsec,
  input  logic              req_frame,
  input  logic [CFR_AW-1:0] req_addr,
  output logic              wr_ctrl,
  output logic              wr_scale,
  output logic              rd_grant,
  output logic              deny
);
  logic is_ctl;
  logic ctl_ok;

  always_comb begin
    is_ctl   = (req_frame == FRAME_CTRL);
    ctl_ok   = is_ctl && !req_nsec;
    deny     = acc && ((is_ctl && req_nsec) || (!is_ctl && req_write));
    wr_ctrl  = acc && req_write && ctl_ok && (req_addr == OFS_CTRL);
    wr_scale = acc && req_write && ctl_ok && (req_addr == OFS_SCALE);
    rd_grant = acc && !req_write && !deny;
  end
endmodule

// File: rtl/cfr_ctrl_regs.sv
module cfr_ctrl_regs
  import cfr_pkg::*;
#(
  parameter int NUM_FREQ = 4,
  parameter logic [NUM_FREQ*32-1:0] FREQ_TABLE = '0,
  parameter bit SCALE_IMPL = 1'b1,
  localparam int FSEL_W = $clog2(NUM_FREQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_scale,
  input  logic [CFR_DW-1:0] wdata,
  input  logic              dbg_req,
  output logic              en,
  output logic              halt_dbg,
  output logic              scale_en,
  output logic [FSEL_W-1:0] fsel,
  output logic [CFR_DW-1:0] scale_inc,
  output logic              halt
);
  // valid: inside the table, and no zero entry at or before idx
  function automatic logic freq_ok(input logic [FSEL_W-1:0] idx);
    logic ok;
    ok = (int'(idx) < NUM_FREQ);
    for (int i = 0; i < NUM_FREQ; i++)
      if (i <= int'(idx) && FREQ_TABLE[32*i +: 32] == 32'd0) ok = 1'b0;
    return ok;
  endfunction

  logic [FSEL_W-1:0] wsel;
  logic              set_ok;
  logic              sel_ok;   // brought out for assertions
  logic              cfg_lock;

  assign wsel     = wdata[FSEL_LSB +: FSEL_W];
  assign set_ok   = wdata[BIT_EN] && freq_ok(wsel);
  assign sel_ok   = freq_ok(fsel);
  assign cfg_lock = en;
  assign halt     = halt_dbg & dbg_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      halt_dbg <= 1'b0;
      fsel     <= '0;
    end else if (wr_ctrl) begin
      en       <= set_ok;
      halt_dbg <= wdata[BIT_HALT];
      fsel     <= wsel;
    end
  end

  generate
    if (SCALE_IMPL) begin : g_scale
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scale_en  <= 1'b0;
          scale_inc <= '0;
        end else if (!cfg_lock) begin
          if (wr_ctrl)  scale_en  <= wdata[BIT_SCALE];
          if (wr_scale) scale_inc <= wdata;
        end
      end
    end else begin : g_noscale
      assign scale_en  = 1'b0;
      assign scale_inc = '0;
    end
  endgenerate

  assert_en_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> sel_ok);
  assert_scale_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ($stable(scale_inc) && $stable(scale_en)));
  assert_halt_needs_dbg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_req |-> !halt);
  assert_halt_needs_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_dbg |-> !halt);
endmodule

// File: rtl/cfr_rdmux.sv
module cfr_rdmux
  import cfr_pkg::*;
#(
  parameter int NUM_FREQ = 4,
  parameter logic [NUM_FREQ*32-1:0] FREQ_TABLE = '0,
  parameter bit SCALE_IMPL = 1'b1,
  localparam int FSEL_W = $clog2(NUM_FREQ)
) (
  input  logic              req_frame,
  input  logic [CFR_AW-1:0] req_addr,
  input  logic              en,
  input  logic              halt_dbg,
  input  logic              scale_en,
  input  logic [FSEL_W-1:0] fsel,
  input  logic [CFR_DW-1:0] scale_inc,
  input  logic              halt,
  input  logic              cnt_running,
  input  logic [63:0]       cnt_value,
  output logic [CFR_DW-1:0] rdata
);
  logic [CFR_DW-1:0] ctrl_word;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[BIT_EN]    = en;
    ctrl_word[BIT_HALT]  = halt_dbg;
    ctrl_word[BIT_SCALE] = scale_en;
    ctrl_word[FSEL_LSB +: FSEL_W] = fsel;
  end

  always_comb begin
    rdata = '0;
    if (req_addr == OFS_CNT_LO) rdata = cnt_value[31:0];
    else if (req_addr == OFS_CNT_HI) rdata = cnt_value[63:32];
    else if (req_frame == FRAME_CTRL) begin
      if (req_addr == OFS_CTRL)  rdata = ctrl_word;
      if (req_addr == OFS_STAT)  rdata = {30'd0, halt, cnt_running};
      if (req_addr == OFS_SCALE) rdata = scale_inc;
      if (req_addr == OFS_IDENT) rdata = {31'd0, SCALE_IMPL};
      for (int i = 0; i < NUM_FREQ; i++)
        if (req_addr == ftab_ofs(i)) rdata = FREQ_TABLE[32*i +: 32];
    end
  end
endmodule

// File: rtl/cnt_frames.sv
module cnt_frames
  import cfr_pkg::*;
#(
  parameter int NUM_FREQ = 4,
  parameter logic [NUM_FREQ*32-1:0] FREQ_TABLE =
    {32'd12_000_000, 32'd0, 32'd50_000_000, 32'd100_000_000},
  parameter bit SCALE_IMPL = 1'b1,
  localparam int FSEL_W = $clog2(NUM_FREQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_nsec,
  input  logic              req_frame,
  input  logic [7:0]        req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  input  logic [63:0]       cnt_value,
  input  logic              cnt_running,
  input  logic              dbg_req,
  output logic              ctl_enable,
  output logic              ctl_scale_en,
  output logic [FSEL_W-1:0] ctl_freq_sel,
  output logic [31:0]       ctl_scale_inc,
  output logic              ctl_halt
);
  logic acc, wr_ctrl, wr_scale, rd_grant, deny, halt_dbg;
  logic [CFR_DW-1:0] mux_data;

  assign req_ready = 1'b1;
  assign acc       = req_valid && req_ready;

  cfr_decode u_decode (
    .acc(acc), .req_write(req_write), .req_nsec(req_nsec), .req_frame(req_frame),
    .req_addr(req_addr), .wr_ctrl(wr_ctrl), .wr_scale(wr_scale),
    .rd_grant(rd_grant), .deny(deny)
  );

  cfr_ctrl_regs #(.NUM_FREQ(NUM_FREQ), .FREQ_TABLE(FREQ_TABLE), .SCALE_IMPL(SCALE_IMPL)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_scale(wr_scale), .wdata(req_wdata),
    .dbg_req(dbg_req), .en(ctl_enable), .halt_dbg(halt_dbg), .scale_en(ctl_scale_en),
    .fsel(ctl_freq_sel), .scale_inc(ctl_scale_inc), .halt(ctl_halt)
  );

  cfr_rdmux #(.NUM_FREQ(NUM_FREQ), .FREQ_TABLE(FREQ_TABLE), .SCALE_IMPL(SCALE_IMPL)) u_mux (
    .req_frame(req_frame), .req_addr(req_addr), .en(ctl_enable), .halt_dbg(halt_dbg),
    .scale_en(ctl_scale_en), .fsel(ctl_freq_sel), .scale_inc(ctl_scale_inc),
    .halt(ctl_halt), .cnt_running(cnt_running), .cnt_value(cnt_value), .rdata(mux_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc;
      rsp_err   <= deny;
      rsp_rdata <= rd_grant ? mux_data : '0;
    end
  end

  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  assert_no_idle_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);
  assert_ns_ctl_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_nsec && req_frame == FRAME_CTRL) |=> (rsp_err && rsp_rdata == '0));
  assert_ns_ctl_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_nsec && req_frame == FRAME_CTRL)
      |=> ($stable(ctl_enable) && $stable(ctl_scale_inc) && $stable(ctl_freq_sel)));
  assert_read_frame_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_frame == FRAME_READ) |=> !rsp_err);
  assert_read_frame_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_frame == FRAME_READ)
      |=> (rsp_err && $stable(ctl_enable) && $stable(ctl_scale_inc)));
endmodule

// File: tb/cnt_frames_tb.sv
module cnt_frames_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] F0 = 32'd100_000_000, F1 = 32'd50_000_000, F3 = 32'd12_000_000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_nsec = 0, req_frame = 0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [63:0] cnt_value = '0;
  logic cnt_running = 0, dbg_req = 0;
  logic ctl_enable, ctl_scale_en, ctl_halt;
  logic [1:0] ctl_freq_sel;
  logic [31:0] ctl_scale_inc;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] rd;
  logic er;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnt_frames u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_nsec(req_nsec), .req_frame(req_frame),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .cnt_value(cnt_value),
    .cnt_running(cnt_running), .dbg_req(dbg_req), .ctl_enable(ctl_enable),
    .ctl_scale_en(ctl_scale_en), .ctl_freq_sel(ctl_freq_sel),
    .ctl_scale_inc(ctl_scale_inc), .ctl_halt(ctl_halt)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bus access; response sampled on the falling edge after the accepting edge
  task automatic access(input logic frame, input logic ns, input logic wr,
                        input logic [7:0] addr, input logic [31:0] wd,
                        output logic [31:0] rdata, output logic err);
    @(negedge clk);
    req_valid = 1; req_frame = frame; req_nsec = ns; req_write = wr;
    req_addr = addr; req_wdata = wd;
    chk("R1 ready", {63'd0, req_ready}, 64'd1);
    @(negedge clk);
    req_valid = 0; req_write = 0;
    chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd1);
    rdata = rsp_rdata; err = rsp_err;
  endtask

  task automatic t_reset();
    chk("R12 enable", {63'd0, ctl_enable}, 0);
    chk("R12 scale_inc", {32'd0, ctl_scale_inc}, 0);
    chk("R12 halt", {63'd0, ctl_halt}, 0);
    access(0, 0, 0, 8'h00, 0, rd, er);
    chk("R12 ctrl word", {32'd0, rd}, 0);
  endtask

  task automatic t_ident_table();
    access(0, 0, 0, 8'h1C, 0, rd, er); chk("R9 ident", {32'd0, rd}, 1);
    access(0, 0, 0, 8'h20, 0, rd, er); chk("R10 f0", {32'd0, rd}, {32'd0, F0});
    access(0, 0, 0, 8'h24, 0, rd, er); chk("R10 f1", {32'd0, rd}, {32'd0, F1});
    access(0, 0, 0, 8'h28, 0, rd, er); chk("R10 f2", {32'd0, rd}, 0);
    access(0, 0, 0, 8'h2C, 0, rd, er); chk("R10 f3", {32'd0, rd}, {32'd0, F3});
    access(0, 0, 0, 8'h30, 0, rd, er); chk("R10 past end", {32'd0, rd}, 0);
  endtask

  task automatic t_enable_gate();
    access(0, 0, 1, 8'h00, 32'h0000_0201, rd, er);
    chk("R6 terminator refused", {63'd0, ctl_enable}, 0);
    access(0, 0, 1, 8'h00, 32'h0000_0301, rd, er);
    chk("R6 beyond terminator refused", {63'd0, ctl_enable}, 0);
    access(0, 0, 0, 8'h00, 0, rd, er);
    chk("R5 readback refused", {32'd0, rd}, 64'h300);
    access(0, 0, 1, 8'h00, 32'h0000_0101, rd, er);
    chk("R6 valid accepted", {63'd0, ctl_enable}, 1);
    chk("R5 sel port", {62'd0, ctl_freq_sel}, 1);
    access(0, 0, 0, 8'h00, 0, rd, er);
    chk("R5 readback", {32'd0, rd}, 64'h101);
    access(0, 0, 1, 8'h00, 32'h0, rd, er);
    chk("R6 clear", {63'd0, ctl_enable}, 0);
  endtask

  task automatic t_scale_lock();
    access(0, 0, 1, 8'h10, 32'h0180_0000, rd, er);
    access(0, 0, 1, 8'h00, 32'h0000_0004, rd, er);
    chk("R7 scale_en while off", {63'd0, ctl_scale_en}, 1);
    access(0, 0, 1, 8'h00, 32'h0000_0105, rd, er);
    chk("R7 enabled", {63'd0, ctl_enable}, 1);
    access(0, 0, 1, 8'h10, 32'h0300_0000, rd, er);
    access(0, 0, 0, 8'h10, 0, rd, er);
    chk("R7 inc frozen rd", {32'd0, rd}, 64'h0180_0000);
    chk("R7 inc frozen port", {32'd0, ctl_scale_inc}, 64'h0180_0000);
    access(0, 0, 1, 8'h00, 32'h0000_0101, rd, er);
    access(0, 0, 0, 8'h00, 0, rd, er);
    chk("R7 scale_en frozen", {32'd0, rd}, 64'h105);
  endtask

  task automatic t_nonsecure();
    access(0, 1, 1, 8'h00, 32'h0, rd, er);
    chk("R2 ns write err", {63'd0, er}, 1);
    chk("R2 ns write ignored", {63'd0, ctl_enable}, 1);
    access(0, 1, 0, 8'h00, 0, rd, er);
    chk("R2 ns read err", {63'd0, er}, 1);
    chk("R2 ns read zero", {32'd0, rd}, 0);
  endtask

  task automatic t_read_frame();
    cnt_value = 64'h1234_5678_9ABC_DEF0;
    access(1, 1, 0, 8'h08, 0, rd, er);
    chk("R3 ns lo", {31'd0, er, rd}, 64'h9ABC_DEF0);
    access(1, 1, 0, 8'h0C, 0, rd, er);
    chk("R3 ns hi", {31'd0, er, rd}, 64'h1234_5678);
    access(1, 0, 0, 8'h08, 0, rd, er);
    chk("R3 sec lo", {31'd0, er, rd}, 64'h9ABC_DEF0);
    access(1, 0, 0, 8'h00, 0, rd, er);
    chk("R3 other ofs", {31'd0, er, rd}, 0);
    access(1, 0, 1, 8'h08, 32'h0, rd, er);
    chk("R4 write err", {63'd0, er}, 1);
    access(1, 0, 1, 8'h00, 32'h0, rd, er);
    access(0, 0, 0, 8'h00, 0, rd, er);
    chk("R4 ctrl unchanged", {32'd0, rd}, 64'h105);
  endtask

  task automatic t_status_halt();
    cnt_running = 1; dbg_req = 1;
    access(0, 0, 0, 8'h04, 0, rd, er);
    chk("R8 running", {32'd0, rd}, 1);
    chk("R11 no bit no halt", {63'd0, ctl_halt}, 0);
    access(0, 0, 1, 8'h00, 32'h0000_0107, rd, er);
    chk("R11 halt", {63'd0, ctl_halt}, 1);
    access(0, 0, 0, 8'h04, 0, rd, er);
    chk("R8 halted", {32'd0, rd}, 3);
    @(negedge clk); dbg_req = 0; #1;
    chk("R11 release", {63'd0, ctl_halt}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ident_table();
    t_enable_gate();
    t_scale_lock();
    t_nonsecure();
    t_read_frame();
    t_status_halt();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule